// File: doc/BRIEF.md
# Tile Edge-List Gather/Scatter Engine

The engine carries out the graph communication step of a graph neural network layer for one tile of the graph. A tile is described by a coordinate-form edge list: each entry holds a local source vertex and a local destination vertex, and the number of live entries comes with the command. Each edge and each vertex owns an embedding of `dim` signed elements in the embedding memory. Scatter copies a vertex embedding onto every edge that leaves it (out-edge mode) or every edge that enters it (in-edge mode). Gather folds the embeddings of all edges into their destination vertex, with either a wrapping sum or a signed maximum.

A command is offered on a valid/ready handshake. The engine takes one command at a time and holds `cmd_ready` low until it is idle again, so a command held valid while the engine is busy simply waits. The engine walks the edges in index order. For each edge it reads the edge-list entry once, then handles the embedding one element at a time through a read port and a write port on the embedding memory. Both memory ports are plain fixed-latency ports with no back-pressure: read data is valid in the cycle after the read enable. A one-cycle `done` pulse closes every command.

Top module: `gse_engine`

## Requirements
- R1: A command is taken on a rising clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the engine is idle, so a command presented during a busy period is not taken and has no effect on memory.
- R2: Opcode 2'b00 (scatter to out-edges): for each edge e below the edge count and each element k below dim, the word at `dst_base + e*dim + k` becomes the word at `src_base + src(e)*dim + k`.
- R3: Opcode 2'b01 (scatter to in-edges): the same as R2, except that the vertex used is dst(e).
- R4: Opcode 2'b10 (gather sum): the word at `dst_base + dst(e)*dim + k` accumulates the word at `src_base + e*dim + k` over all edges, as a wrapping DATA_W-bit sum. The accumulator starts from zero when an edge first touches that destination, and its prior memory contents are ignored.
- R5: Opcode 2'b11 (gather max): the same as R4 with a signed maximum, and the accumulator starts from the most negative DATA_W-bit value.
- R6: Exactly edges*dim words are written per command. A destination vertex with no edge in the tile, and every address outside the written regions, keep their contents.
- R7: Edge e of tile t is read from edge-list index `t*2^EID_W + e`. Edges are processed in ascending order, and list read data is valid one cycle after `el_rd_en`.
- R8: `done` is high for exactly one cycle, and that cycle follows the last memory write. Counting from the accepting edge, `done` appears in cycle edges*(2 + c*dim) + 1, where c is 2 for scatter and 3 for gather. With an edge count of 0, `done` appears in cycle 1 and no memory is accessed.
- R9: Embedding read data is taken one cycle after `emb_rd_en`, and a read and a write are never issued in the same cycle.
- R10: While reset is active and directly after it, `cmd_ready` is 1 and `done`, `emb_wr_en`, `emb_rd_en` and `el_rd_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous active-low reset |
| cmd_valid | input | 1 | command offered |
| cmd_ready | output | 1 | engine idle, command will be taken |
| cmd_op | input | 2 | operation code (R2 to R5) |
| cmd_tile | input | TILE_W | tile number used for edge-list addressing |
| cmd_edges | input | EID_W+1 | number of edges, 0 to 2^EID_W |
| cmd_dim | input | DIM_W | elements per embedding, at least 1 |
| cmd_src_base | input | ADDR_W | base address of the embeddings read |
| cmd_dst_base | input | ADDR_W | base address of the embeddings written |
| el_rd_en | output | 1 | edge-list read request |
| el_rd_addr | output | TILE_W+EID_W | edge-list index |
| el_rd_src | input | VID_W | source vertex of the requested edge (next cycle) |
| el_rd_dst | input | VID_W | destination vertex of the requested edge (next cycle) |
| emb_rd_en | output | 1 | embedding read request |
| emb_rd_addr | output | ADDR_W | embedding read address |
| emb_rd_data | input | DATA_W | embedding read data (next cycle) |
| emb_wr_en | output | 1 | embedding write enable |
| emb_wr_addr | output | ADDR_W | embedding write address |
| emb_wr_data | output | DATA_W | embedding write data |
| done | output | 1 | one-cycle end-of-command pulse |

## Verification
All four operations run over edge lists that are generated per tile. The destinations fall in only seven of the sixteen vertices and repeat, so the whole-memory comparison shows whether untouched vertices are preserved and whether several edges fold correctly into one vertex. Gather-max runs on all-negative edge data, which separates an accumulator that starts from the most negative value from one that starts from zero. Gather-sum runs on non-zero prior destination contents, which exposes an accumulator that reads stale memory on the first touch. A full 64-edge tile, a 16-element embedding, a zero-edge command and a command presented while the engine is busy cover the count limits, the exact latency and the handshake.

// File: rtl/gse_pkg.sv
package gse_pkg;
  typedef enum logic [1:0] {
    OP_SCAT_OUT = 2'b00,
    OP_SCAT_IN  = 2'b01,
    OP_GATH_SUM = 2'b10,
    OP_GATH_MAX = 2'b11
  } gs_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_EWAIT, ST_RDA, ST_RDB, ST_WR, ST_DONE
  } gs_state_e;
endpackage

// File: rtl/gse_addr_gen.sv
module gse_addr_gen #(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 7,
  parameter int DIM_W  = 5
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DIM_W-1:0]  dim_i,
  input  logic [DIM_W-1:0]  elem_i,
  output logic [ADDR_W-1:0] addr_o
);
  // row-major: one embedding of dim_i words per index
  assign addr_o = base_i + ADDR_W'(idx_i) * ADDR_W'(dim_i) + ADDR_W'(elem_i);
endmodule

// File: rtl/gse_reduce.sv
module gse_reduce #(
  parameter int DATA_W = 16
) (
  input  logic              is_max_i,
  input  logic              first_i,
  input  logic [DATA_W-1:0] edge_i,
  input  logic [DATA_W-1:0] acc_i,
  output logic [DATA_W-1:0] res_o
);
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  logic [DATA_W-1:0] start;

  always_comb begin
    if (first_i) start = is_max_i ? MOST_NEG : '0;
    else         start = acc_i;
    if (is_max_i) res_o = ($signed(edge_i) > $signed(start)) ? edge_i : start;
    else          res_o = start + edge_i;
  end
endmodule

// File: rtl/gse_touch.sv
module gse_touch #(
  parameter int VID_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             set_i,
  input  logic [VID_W-1:0] set_idx_i,
  input  logic [VID_W-1:0] qry_idx_i,
  output logic             hit_o
);
  localparam int NV = 1 << VID_W;
  logic [NV-1:0] seen;

  for (genvar i = 0; i < NV; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                      seen[i] <= 1'b0;
      else if (clr_i)                                  seen[i] <= 1'b0;
      else if (set_i && (set_idx_i == VID_W'(i)))      seen[i] <= 1'b1;
    end
  end

  assign hit_o = seen[qry_idx_i];

  // R4/R5: within a command a touched destination never reverts to untouched
  assert_touch_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> ((seen & $past(seen)) == $past(seen)));
endmodule

// File: rtl/gse_engine.sv
module gse_engine
  import gse_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10,
  parameter int VID_W  = 4,
  parameter int EID_W  = 6,
  parameter int TILE_W = 4,
  parameter int DIM_W  = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  output logic                    cmd_ready,
  input  logic [1:0]              cmd_op,
  input  logic [TILE_W-1:0]       cmd_tile,
  input  logic [EID_W:0]          cmd_edges,
  input  logic [DIM_W-1:0]        cmd_dim,
  input  logic [ADDR_W-1:0]       cmd_src_base,
  input  logic [ADDR_W-1:0]       cmd_dst_base,
  output logic                    el_rd_en,
  output logic [TILE_W+EID_W-1:0] el_rd_addr,
  input  logic [VID_W-1:0]        el_rd_src,
  input  logic [VID_W-1:0]        el_rd_dst,
  output logic                    emb_rd_en,
  output logic [ADDR_W-1:0]       emb_rd_addr,
  input  logic [DATA_W-1:0]       emb_rd_data,
  output logic                    emb_wr_en,
  output logic [ADDR_W-1:0]       emb_wr_addr,
  output logic [DATA_W-1:0]       emb_wr_data,
  output logic                    done
);
  localparam int IDX_W = (EID_W + 1 > VID_W) ? EID_W + 1 : VID_W;

  gs_state_e         state;
  gs_op_e            op_q;
  logic [TILE_W-1:0] tile_q;
  logic [EID_W:0]    ecnt_q, eidx;
  logic [DIM_W-1:0]  dim_q, elem;
  logic [ADDR_W-1:0] sbase_q, dbase_q;
  logic [VID_W-1:0]  vsrc_q, vdst_q;
  logic [DATA_W-1:0] a_q;

  logic is_gather, accept, last_elem, first_touch;
  logic [IDX_W-1:0]  rd_idx, wr_idx;
  logic [ADDR_W-1:0] a_addr, w_addr;
  logic [DATA_W-1:0] red_out;

  assign is_gather = op_q[1];
  assign accept    = cmd_valid && cmd_ready;
  assign last_elem = (elem == dim_q - 1'b1);

  // index selection per operation: edge index or vertex id
  always_comb begin
    unique case (op_q)
      OP_SCAT_OUT: rd_idx = IDX_W'(vsrc_q);
      OP_SCAT_IN:  rd_idx = IDX_W'(vdst_q);
      default:     rd_idx = IDX_W'(eidx);
    endcase
    wr_idx = is_gather ? IDX_W'(vdst_q) : IDX_W'(eidx);
  end

  gse_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DIM_W(DIM_W)) u_rd_ag (
    .base_i(sbase_q), .idx_i(rd_idx), .dim_i(dim_q), .elem_i(elem), .addr_o(a_addr));

  gse_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DIM_W(DIM_W)) u_wr_ag (
    .base_i(dbase_q), .idx_i(wr_idx), .dim_i(dim_q), .elem_i(elem), .addr_o(w_addr));

  gse_touch #(.VID_W(VID_W)) u_touch (
    .clk(clk), .rst_n(rst_n), .clr_i(accept),
    .set_i((state == ST_WR) && last_elem), .set_idx_i(vdst_q),
    .qry_idx_i(vdst_q), .hit_o(first_touch));

  gse_reduce #(.DATA_W(DATA_W)) u_red (
    .is_max_i(op_q == OP_GATH_MAX), .first_i(!first_touch),
    .edge_i(a_q), .acc_i(emb_rd_data), .res_o(red_out));

  // outputs decoded from state
  assign cmd_ready   = (state == ST_IDLE);
  assign done        = (state == ST_DONE);
  assign el_rd_en    = (state == ST_FETCH);
  assign el_rd_addr  = {tile_q, eidx[EID_W-1:0]};
  assign emb_rd_en   = (state == ST_RDA) || (state == ST_RDB);
  assign emb_rd_addr = (state == ST_RDB) ? w_addr : a_addr;
  assign emb_wr_en   = (state == ST_WR);
  assign emb_wr_addr = w_addr;
  assign emb_wr_data = is_gather ? red_out : emb_rd_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_SCAT_OUT;
      tile_q  <= '0;
      ecnt_q  <= '0;
      dim_q   <= '0;
      sbase_q <= '0;
      dbase_q <= '0;
      eidx    <= '0;
      elem    <= '0;
      vsrc_q  <= '0;
      vdst_q  <= '0;
      a_q     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) begin
          op_q    <= gs_op_e'(cmd_op);
          tile_q  <= cmd_tile;
          ecnt_q  <= cmd_edges;
          dim_q   <= cmd_dim;
          sbase_q <= cmd_src_base;
          dbase_q <= cmd_dst_base;
          eidx    <= '0;
          elem    <= '0;
          state   <= (cmd_edges == '0) ? ST_DONE : ST_FETCH;
        end
        ST_FETCH: state <= ST_EWAIT;
        ST_EWAIT: begin
          vsrc_q <= el_rd_src;
          vdst_q <= el_rd_dst;
          state  <= ST_RDA;
        end
        ST_RDA: state <= is_gather ? ST_RDB : ST_WR;
        ST_RDB: begin
          a_q   <= emb_rd_data;
          state <= ST_WR;
        end
        ST_WR: begin
          if (last_elem) begin
            elem  <= '0;
            eidx  <= eidx + 1'b1;
            state <= (eidx + 1'b1 == ecnt_q) ? ST_DONE : ST_FETCH;
          end else begin
            elem  <= elem + 1'b1;
            state <= ST_RDA;
          end
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_ready_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!emb_wr_en && !emb_rd_en && !el_rd_en));
  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(emb_wr_en) || $past(accept)));
  assert_list_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    el_rd_en |=> (!el_rd_en && !emb_wr_en));
  assert_no_rw_same_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(emb_rd_en && emb_wr_en));
  assert_max_not_below_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (emb_wr_en && op_q == OP_GATH_MAX) |-> ($signed(emb_wr_data) >= $signed(a_q)));
endmodule

// File: tb/gse_engine_tb.sv
`timescale 1ns/1ps
module gse_engine_tb;
  localparam int NV = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [3:0]  cmd_tile = '0;
  logic [6:0]  cmd_edges = '0;
  logic [4:0]  cmd_dim = 5'd1;
  logic [9:0]  cmd_src_base = '0, cmd_dst_base = '0;
  logic        el_rd_en;
  logic [9:0]  el_rd_addr;
  logic [3:0]  el_rd_src, el_rd_dst;
  logic        emb_rd_en, emb_wr_en, done;
  logic [9:0]  emb_rd_addr, emb_wr_addr;
  logic [15:0] emb_rd_data, emb_wr_data;

  gse_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_tile(cmd_tile), .cmd_edges(cmd_edges), .cmd_dim(cmd_dim),
    .cmd_src_base(cmd_src_base), .cmd_dst_base(cmd_dst_base),
    .el_rd_en(el_rd_en), .el_rd_addr(el_rd_addr), .el_rd_src(el_rd_src), .el_rd_dst(el_rd_dst),
    .emb_rd_en(emb_rd_en), .emb_rd_addr(emb_rd_addr), .emb_rd_data(emb_rd_data),
    .emb_wr_en(emb_wr_en), .emb_wr_addr(emb_wr_addr), .emb_wr_data(emb_wr_data), .done(done));

  logic [15:0] mem   [0:1023];
  logic [15:0] model [0:1023];
  logic [3:0]  lsrc  [0:1023];
  logic [3:0]  ldst  [0:1023];
  int wr_cnt = 0;
  int coll = 0;

  always @(posedge clk) begin
    if (emb_rd_en) emb_rd_data <= mem[emb_rd_addr];
    if (emb_wr_en) begin
      mem[emb_wr_addr] <= emb_wr_data;
      wr_cnt <= wr_cnt + 1;
    end
    if (emb_rd_en && emb_wr_en) coll <= coll + 1;
    if (el_rd_en) begin
      el_rd_src <= lsrc[el_rd_addr];
      el_rd_dst <= ldst[el_rd_addr];
    end
  end

  int total = 0;
  int bad = 0;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // reference behaviour taken from the requirements
  task automatic ref_apply(int op, int t, int ne, int d, int sb, int db);
    bit tch [16];
    for (int v = 0; v < 16; v++) tch[v] = 1'b0;
    for (int e = 0; e < ne; e++) begin
      int s  = lsrc[t*64 + e];
      int dd = ldst[t*64 + e];
      for (int k = 0; k < d; k++) begin
        if (op == 0)      model[(db + e*d + k) & 1023] = model[(sb + s*d + k) & 1023];
        else if (op == 1) model[(db + e*d + k) & 1023] = model[(sb + dd*d + k) & 1023];
        else begin
          logic [15:0] x, acc;
          int a;
          x = model[(sb + e*d + k) & 1023];
          a = (db + dd*d + k) & 1023;
          acc = tch[dd] ? model[a] : ((op == 3) ? 16'h8000 : 16'h0000);
          if (op == 2) model[a] = acc + x;
          else         model[a] = ($signed(x) > $signed(acc)) ? x : acc;
        end
      end
      tch[dd] = 1'b1;
    end
  endtask

  task automatic cmp_mem(string req);
    int mism = 0;
    for (int i = 0; i < 1024; i++)
      if (mem[i] !== model[i]) begin
        if (mism == 0) $display("  first mismatch at %0d: got %h want %h", i, mem[i], model[i]);
        mism++;
      end
    chk(req, "memory words differing", mism, 0);
  endtask

  task automatic drive_cmd(int op, int t, int ne, int d, int sb, int db);
    cmd_valid    = 1'b1;
    cmd_op       = 2'(op);
    cmd_tile     = 4'(t);
    cmd_edges    = 7'(ne);
    cmd_dim      = 5'(d);
    cmd_src_base = 10'(sb);
    cmd_dst_base = 10'(db);
  endtask

  // drive at a falling edge where cmd_ready is high; returns cycles to done
  task automatic run_cmd(int op, int t, int ne, int d, int sb, int db, output int cyc);
    drive_cmd(op, t, ne, d, sb, db);
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    if (!done) begin
      $display("FAIL R8 done never seen actual=0 expected=1");
      bad++;
      total++;
    end
  endtask

  localparam int NC = 7;
  localparam int V_OP [NC] = '{0, 1, 2, 3, 3, 2, 0};
  localparam int V_T  [NC] = '{0, 1, 2, 3, 4, 5, 6};
  localparam int V_E  [NC] = '{8, 10, 12, 6, 9, 64, 1};
  localparam int V_D  [NC] = '{3, 2, 4, 4, 1, 1, 16};
  localparam int V_SB [NC] = '{100, 200, 500, 0, 600, 0, 100};
  localparam int V_DB [NC] = '{300, 400, 700, 800, 900, 950, 960};

  function automatic string op_req(int op);
    case (op)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL R8 watchdog expired actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int cyc, w0;
    for (int i = 0; i < 1024; i++) begin
      mem[i]   = 16'(i*97 - 3000);
      model[i] = 16'(i*97 - 3000);
      lsrc[i]  = 4'(((i % 64) * 3 + (i / 64)) % 16);
      ldst[i]  = 4'(((i % 64) * 5 + (i / 64)) % NV);
    end

    // R10: reset state
    repeat (3) @(negedge clk);
    chk("R10", "cmd_ready in reset", int'(cmd_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "done after reset", int'(done), 0);
    chk("R10", "emb enables after reset", int'(emb_wr_en | emb_rd_en), 0);
    chk("R10", "el_rd_en after reset", int'(el_rd_en), 0);

    // table of vectors
    for (int c = 0; c < NC; c++) begin
      int per;
      w0 = wr_cnt;
      run_cmd(V_OP[c], V_T[c], V_E[c], V_D[c], V_SB[c], V_DB[c], cyc);
      ref_apply(V_OP[c], V_T[c], V_E[c], V_D[c], V_SB[c], V_DB[c]);
      per = (V_OP[c] >= 2) ? 3 : 2;
      chk("R8", "cycles to done", cyc, V_E[c] * (2 + per * V_D[c]) + 1);
      @(negedge clk);
      chk("R6", "write count", wr_cnt - w0, V_E[c] * V_D[c]);
      // R7 R9: list order and one-cycle data are implied by a matching memory image
      cmp_mem({op_req(V_OP[c]), " R6 R7 R9"});
    end

    // R8: zero-edge command
    w0 = wr_cnt;
    run_cmd(3, 2, 0, 4, 0, 300, cyc);
    chk("R8", "zero-edge cycles to done", cyc, 1);
    @(negedge clk);
    chk("R8", "zero-edge write count", wr_cnt - w0, 0);
    cmp_mem("R6");

    // R1: a command offered while busy is not taken
    w0 = wr_cnt;
    drive_cmd(0, 7, 4, 2, 100, 980);
    @(negedge clk);
    drive_cmd(2, 2, 5, 1, 0, 300);
    repeat (2) @(negedge clk);
    chk("R1", "cmd_ready while busy", int'(cmd_ready), 0);
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    cmd_valid = 1'b0;
    ref_apply(0, 7, 4, 2, 100, 980);
    repeat (4) @(negedge clk);
    chk("R1", "writes with busy offer", wr_cnt - w0, 8);
    chk("R1", "cmd_ready when idle again", int'(cmd_ready), 1);
    cmp_mem("R1");
    chk("R9", "read/write same-cycle count", coll, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule